// File: doc/BRIEF.md
# Command-Stream Register Writer

This block walks a packed stream of 32-bit command words and turns it into single register writes. Each word arrives on a valid/ready input and is taken on a cycle where both are high. The block decodes a header, reads the payload that belongs to it, and issues one write per data word on a valid/ready write port. Each write carries a byte address and 32 bits of data. The supported commands are:

- a block of consecutive registers;
- a list of offset/value pairs;
- narrow and wide table loads, which stream into a data port that has a low and a high word;
- a base switch, which picks the current write base from a small configurable table of hardware IDs.

Software first loads the base table through the configuration pins. It then pulses `start` with the length of the stream in words and feeds the words in. The block flags an error and stops at the first bad command. When every word has been consumed and the last write has left the port, it pulses `done`.

Back-pressure rules:

- `wr_valid` stays high with stable address and data until `wr_ready` is seen.
- `cmd_ready` is low whenever the write slot is full and not draining.
- `cmd_ready` is also low when idle, after an error, and once the stream's word count is used up.

Top module: `cmdwr_engine`

## Requirements
- R1: After reset `cmd_ready`, `wr_valid`, `done` and `err` are low, and `err_code` is 0.
- R2: Opcode 3, carried in bits 31:24 of a header word, is a two-word header: a count in bits 15:0, then an offset in bits 23:0. The next count words are written to base+offset, base+offset+4, and so on. While no base is selected, the base is 0.
- R3: Opcode 4 is a one-word header with a count in bits 15:0. It is followed by count pairs of words. Each pair writes its second word to base plus its first word.
- R4: Opcode 10 is a three-word header:
  - word 0 holds a byte length minus one in bits 15:0;
  - word 1 is ignored;
  - word 2 holds a target in bits 23:0.
  The block then writes (length+1)/4 words, each to base+target+LO_OFS.
- R5: Opcode 11 has the same header as opcode 10. It writes (length+1)/8 word pairs: the first word of each pair to base+target+LO_OFS, the second to base+target+HI_OFS (defaults 0 and 4).
- R6: Opcode 8 carries an ID in bits 23:0. The lowest-indexed valid table entry with that ID becomes the current base. If no entry matches, the error code is 3.
- R7: A zero count for opcode 3 or 4 gives error code 1. So does any header whose full command needs more words than remain in the stream.
- R8: A table load with no base selected gives error code 2. This check takes precedence over the length check.
- R9: Any other opcode gives error code 4. After any error, `cmd_ready` stays low and `err`/`err_code` hold until the next `start`.
- R10: A write that is not accepted keeps `wr_valid`, `wr_addr` and `wr_data` unchanged, and `cmd_ready` is low during the stall.
- R11: `done` is a one-cycle pulse once all `stream_len` words are consumed without error and the write slot is empty. A length of 0 completes at once.
- R12: `start` clears the error and deselects the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new stream |
| stream_len | input | LEN_W | Stream length in words, sampled at start |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when high with valid |
| cmd_word | input | 32 | Command word |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write target accepts the request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| tab_we | input | 1 | Base table entry write strobe |
| tab_idx | input | TIW | Base table entry index |
| tab_vld | input | 1 | Entry valid bit |
| tab_id | input | ID_W | Entry hardware ID |
| tab_base | input | 32 | Entry base address |
| done | output | 1 | Stream completed pulse |
| err | output | 1 | Error flag |
| err_code | output | 3 | 1 count/length, 2 no base, 3 table miss, 4 bad opcode |

## Verification
A decoder that lands in the wrong state misreads every later word as header or payload. Address and data then go wrong on the very next write, and stray error codes often appear within one or two words. A remaining-count register that is off by one shows as `done` arriving early or never, or as a bounds error on the final command. A wrong base or pair-offset latch shows on the first write of the command that uses it. A slot that loses its hold shows as a dropped or changed write during a random stall on `wr_ready`.

// File: rtl/cmdwr_pkg.sv
package cmdwr_pkg;
  localparam logic [7:0] OP_CONT  = 8'd3;
  localparam logic [7:0] OP_RAND  = 8'd4;
  localparam logic [7:0] OP_BASE  = 8'd8;
  localparam logic [7:0] OP_TBL32 = 8'd10;
  localparam logic [7:0] OP_TBL64 = 8'd11;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_COUNT  = 3'd1,
    ERR_NOBASE = 3'd2,
    ERR_MISS   = 3'd3,
    ERR_OPCODE = 3'd4
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_CONT_OFS, S_CONT_DAT, S_RAND_OFS, S_RAND_VAL,
    S_TBL_MEM, S_TBL_TGT, S_TBL_DAT, S_FAIL
  } st_e;
endpackage

// File: rtl/cmdwr_basetab.sv
module cmdwr_basetab #(
  parameter int N    = 8,
  parameter int ID_W = 24,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic            cfg_vld,
  input  logic [ID_W-1:0] cfg_id,
  input  logic [31:0]     cfg_base,
  input  logic [ID_W-1:0] look_id,
  output logic            hit,
  output logic [31:0]     hit_base
);
  logic            vld_q  [N];
  logic [ID_W-1:0] id_q   [N];
  logic [31:0]     base_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        id_q[g]   <= '0;
        base_q[g] <= '0;
      end else if (cfg_we && (cfg_idx == IW'(g))) begin
        vld_q[g]  <= cfg_vld;
        id_q[g]   <= cfg_id;
        base_q[g] <= cfg_base;
      end
    end
  end

  // Scan from the top so the lowest matching index is the one kept.
  always_comb begin
    hit      = 1'b0;
    hit_base = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i] && (id_q[i] == look_id)) begin
        hit      = 1'b1;
        hit_base = base_q[i];
      end
    end
  end
endmodule

// File: rtl/cmdwr_wslot.sv
module cmdwr_wslot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [31:0]   wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          free
);
  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_addr  <= push_addr;
      wr_data  <= push_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdwr_decode.sv
module cmdwr_decode
  import cmdwr_pkg::*;
#(
  parameter int          LEN_W  = 20,
  parameter logic [31:0] LO_OFS = 32'h0,
  parameter logic [31:0] HI_OFS = 32'h4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] stream_len,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_word,
  output logic             cmd_ready,
  input  logic             slot_free,
  input  logic             slot_busy,
  input  logic             lk_hit,
  input  logic [31:0]      lk_base,
  output logic             push,
  output logic [31:0]      push_addr,
  output logic [31:0]      push_data,
  output logic             done,
  output logic [2:0]       err_code
);
  localparam int CW = ((LEN_W > 18) ? LEN_W : 18) + 1;

  st_e              st;
  logic [LEN_W-1:0] rem;
  logic [16:0]      cnt;
  logic [31:0]      base, addr, pair_off;
  logic             base_ok, wide, hi;
  err_e             ecode;

  logic        accept, run;
  logic [7:0]  op;
  logic [16:0] tbl_bytes, tbl_n;
  logic [CW-1:0] rem_x, need_cont, need_rand, need_tbl;

  assign op        = cmd_word[31:24];
  assign tbl_bytes = {1'b0, cmd_word[15:0]} + 17'd1;
  assign tbl_n     = (op == OP_TBL64) ? {2'b0, tbl_bytes[16:3], 1'b0}
                                      : {2'b0, tbl_bytes[16:2]};
  assign rem_x     = CW'(rem);
  assign need_cont = CW'(cmd_word[15:0]) + CW'(2);
  assign need_rand = (CW'(cmd_word[15:0]) << 1) + CW'(1);
  assign need_tbl  = CW'(tbl_n) + CW'(3);

  assign run       = (st != S_IDLE) && (st != S_FAIL);
  assign cmd_ready = run && slot_free && !((st == S_HDR) && (rem == '0));
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    push      = 1'b0;
    push_addr = addr;
    push_data = cmd_word;
    if (accept) begin
      unique case (st)
        S_CONT_DAT: push = 1'b1;
        S_RAND_VAL: begin
          push      = 1'b1;
          push_addr = base + pair_off;
        end
        S_TBL_DAT: begin
          push      = 1'b1;
          push_addr = addr + ((wide && hi) ? HI_OFS : LO_OFS);
        end
        default: push = 1'b0;
      endcase
    end
  end

  assign err_code = ecode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      cnt      <= '0;
      base     <= '0;
      base_ok  <= 1'b0;
      addr     <= '0;
      pair_off <= '0;
      wide     <= 1'b0;
      hi       <= 1'b0;
      ecode    <= ERR_NONE;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st      <= S_HDR;
        rem     <= stream_len;
        ecode   <= ERR_NONE;
        base    <= '0;
        base_ok <= 1'b0;
      end else if ((st == S_HDR) && (rem == '0)) begin
        if (!slot_busy) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      end else if (accept) begin
        rem <= rem - 1'b1;
        unique case (st)
          S_HDR: begin
            unique case (op)
              OP_CONT: begin
                if ((cmd_word[15:0] == 16'd0) || (need_cont > rem_x)) begin
                  ecode <= ERR_COUNT;
                  st    <= S_FAIL;
                end else begin
                  cnt <= 17'(cmd_word[15:0]);
                  st  <= S_CONT_OFS;
                end
              end
              OP_RAND: begin
                if ((cmd_word[15:0] == 16'd0) || (need_rand > rem_x)) begin
                  ecode <= ERR_COUNT;
                  st    <= S_FAIL;
                end else begin
                  cnt <= 17'(cmd_word[15:0]);
                  st  <= S_RAND_OFS;
                end
              end
              OP_BASE: begin
                if (lk_hit) begin
                  base    <= lk_base;
                  base_ok <= 1'b1;
                end else begin
                  ecode <= ERR_MISS;
                  st    <= S_FAIL;
                end
              end
              OP_TBL32, OP_TBL64: begin
                if (!base_ok) begin
                  ecode <= ERR_NOBASE;
                  st    <= S_FAIL;
                end else if (need_tbl > rem_x) begin
                  ecode <= ERR_COUNT;
                  st    <= S_FAIL;
                end else begin
                  cnt  <= tbl_n;
                  wide <= (op == OP_TBL64);
                  st   <= S_TBL_MEM;
                end
              end
              default: begin
                ecode <= ERR_OPCODE;
                st    <= S_FAIL;
              end
            endcase
          end
          S_CONT_OFS: begin
            addr <= base + {8'b0, cmd_word[23:0]};
            st   <= S_CONT_DAT;
          end
          S_CONT_DAT: begin
            addr <= addr + 32'd4;
            cnt  <= cnt - 1'b1;
            if (cnt == 17'd1) st <= S_HDR;
          end
          S_RAND_OFS: begin
            pair_off <= cmd_word;
            st       <= S_RAND_VAL;
          end
          S_RAND_VAL: begin
            cnt <= cnt - 1'b1;
            st  <= (cnt == 17'd1) ? S_HDR : S_RAND_OFS;
          end
          S_TBL_MEM: st <= S_TBL_TGT;
          S_TBL_TGT: begin
            addr <= base + {8'b0, cmd_word[23:0]};
            hi   <= 1'b0;
            st   <= (cnt == '0) ? S_HDR : S_TBL_DAT;
          end
          S_TBL_DAT: begin
            hi  <= wide ? !hi : 1'b0;
            cnt <= cnt - 1'b1;
            if (cnt == 17'd1) st <= S_HDR;
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdwr_engine.sv
module cmdwr_engine #(
  parameter int          LEN_W  = 20,
  parameter int          TAB_N  = 8,
  parameter int          ID_W   = 24,
  parameter logic [31:0] LO_OFS = 32'h0,
  parameter logic [31:0] HI_OFS = 32'h4,
  localparam int         TIW    = (TAB_N > 1) ? $clog2(TAB_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] stream_len,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [31:0]      cmd_word,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [31:0]      wr_addr,
  output logic [31:0]      wr_data,
  input  logic             tab_we,
  input  logic [TIW-1:0]   tab_idx,
  input  logic             tab_vld,
  input  logic [ID_W-1:0]  tab_id,
  input  logic [31:0]      tab_base,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);
  logic        lk_hit, push, slot_free;
  logic [31:0] lk_base, push_addr, push_data;

  cmdwr_basetab #(.N(TAB_N), .ID_W(ID_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(tab_we), .cfg_idx(tab_idx), .cfg_vld(tab_vld),
    .cfg_id(tab_id), .cfg_base(tab_base),
    .look_id(cmd_word[ID_W-1:0]), .hit(lk_hit), .hit_base(lk_base)
  );

  cmdwr_decode #(.LEN_W(LEN_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_dec (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_len(stream_len),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .slot_free(slot_free), .slot_busy(wr_valid),
    .lk_hit(lk_hit), .lk_base(lk_base),
    .push(push), .push_addr(push_addr), .push_data(push_data),
    .done(done), .err_code(err_code)
  );

  cmdwr_wslot #(.DW(32)) u_slot (
    .clk(clk), .rst_n(rst_n), .push(push),
    .push_addr(push_addr), .push_data(push_data),
    .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .free(slot_free)
  );

  assign err = (err_code != 3'd0);
endmodule

// File: rtl/cmdwr_chk.sv
module cmdwr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_ready,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        done,
  input logic        err,
  input logic [2:0]  err_code
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !cmd_ready);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err && $stable(err_code));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_ready);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err);
endmodule

bind cmdwr_engine cmdwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .done(done), .err(err), .err_code(err_code)
);

// File: tb/sim_cmdwr_engine.sv
`timescale 1ns/100ps
module sim_cmdwr_engine;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [19:0] stream_len = '0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data;
  logic        tab_we = 1'b0, tab_vld = 1'b0;
  logic [2:0]  tab_idx = '0;
  logic [23:0] tab_id = '0;
  logic [31:0] tab_base = '0;
  logic        done, err;
  logic [2:0]  err_code;

  int n_chk = 0, n_bad = 0;
  bit stall_en = 1'b0;
  logic [7:0] lf = 8'h5A;

  logic [31:0] exp_addr [64];
  logic [31:0] exp_data [64];
  string       exp_tag  [64];
  int exp_n = 0, got_n = 0;

  always #2 clk = ~clk;

  cmdwr_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_len(stream_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .tab_we(tab_we), .tab_idx(tab_idx), .tab_vld(tab_vld), .tab_id(tab_id),
    .tab_base(tab_base), .done(done), .err(err), .err_code(err_code)
  );

  // {header, word, expect_write, addr, data}
  localparam int NV = 27;
  localparam logic [97:0] VEC [NV] = '{
    {1'b1, 32'h08000123, 1'b0, 32'h0,        32'h0},
    {1'b1, 32'h03000003, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h00000100, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h000000A0, 1'b1, 32'h10000100, 32'h000000A0},
    {1'b0, 32'h000000A1, 1'b1, 32'h10000104, 32'h000000A1},
    {1'b0, 32'h000000A2, 1'b1, 32'h10000108, 32'h000000A2},
    {1'b1, 32'h04000002, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h00000040, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h000000B0, 1'b1, 32'h10000040, 32'h000000B0},
    {1'b0, 32'h00000200, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h000000B1, 1'b1, 32'h10000200, 32'h000000B1},
    {1'b1, 32'h08000456, 1'b0, 32'h0,        32'h0},
    {1'b1, 32'h0A000007, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'hDEADBEEF, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h55000300, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h000000C0, 1'b1, 32'h20000300, 32'h000000C0},
    {1'b0, 32'h000000C1, 1'b1, 32'h20000300, 32'h000000C1},
    {1'b1, 32'h0B00000F, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h12345678, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h00000400, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h000000D0, 1'b1, 32'h20000400, 32'h000000D0},
    {1'b0, 32'h000000D1, 1'b1, 32'h20000404, 32'h000000D1},
    {1'b0, 32'h000000D2, 1'b1, 32'h20000400, 32'h000000D2},
    {1'b0, 32'h000000D3, 1'b1, 32'h20000404, 32'h000000D3},
    {1'b1, 32'h0A000002, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h00000000, 1'b0, 32'h0,        32'h0},
    {1'b0, 32'h00000500, 1'b0, 32'h0,        32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'd3:    return "R2";
      8'd4:    return "R3";
      8'd10:   return "R4";
      8'd11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // wr_ready: changes just after the rising edge
  initial forever begin
    @(posedge clk); #0.5;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    wr_ready = stall_en ? lf[0] : 1'b1;
  end

  // write monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (got_n < exp_n) begin
        chk((wr_addr == exp_addr[got_n]) && (wr_data == exp_data[got_n]),
            exp_tag[got_n], wr_addr, exp_addr[got_n]);
        if (wr_data != exp_data[got_n])
          chk(1'b0, exp_tag[got_n], wr_data, exp_data[got_n]);
      end else begin
        chk(1'b0, "R2 unexpected write", wr_addr, 32'h0);
      end
      got_n++;
    end
  end

  task automatic cfg(input int idx, input bit v, input logic [23:0] id, input logic [31:0] b);
    @(negedge clk);
    tab_we = 1'b1; tab_idx = 3'(idx); tab_vld = v; tab_id = id; tab_base = b;
    @(posedge clk); #0.5;
    tab_we = 1'b0;
  endtask

  task automatic go(input int len);
    @(negedge clk);
    start = 1'b1; stream_len = 20'(len);
    @(posedge clk); #0.5;
    start = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    #0.5;
    while (!cmd_ready) begin
      @(negedge clk); #0.5;
    end
    @(posedge clk); #0.5;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk(seen && !err, req, {31'b0, seen}, 32'h1);
  endtask

  task automatic expect_err(input logic [2:0] code, input string req);
    @(negedge clk);
    chk(err && (err_code == code), req, {29'b0, err_code}, {29'b0, code});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_ready && !wr_valid && !done && !err && err_code == 3'd0, "R1",
        {27'b0, cmd_ready, wr_valid, done, err, 1'b0}, 32'h0);

    // R6 table: entry 5 duplicates id 0x456 and must lose to entry 1
    cfg(0, 1'b1, 24'h000123, 32'h10000000);
    cfg(1, 1'b1, 24'h000456, 32'h20000000);
    cfg(2, 1'b0, 24'h000789, 32'h40000000);
    cfg(5, 1'b1, 24'h000456, 32'h30000000);

    // vector table walk, with random write-port stalls (R10)
    begin
      logic [7:0] cur_op = 8'h0;
      exp_n = 0; got_n = 0;
      for (int i = 0; i < NV; i++) begin
        if (VEC[i][97]) cur_op = VEC[i][96:89];
        if (VEC[i][64]) begin
          exp_addr[exp_n] = VEC[i][63:32];
          exp_data[exp_n] = VEC[i][31:0];
          exp_tag[exp_n]  = tag_of(cur_op);
          exp_n++;
        end
      end
    end
    stall_en = 1'b1;
    go(NV);
    for (int i = 0; i < NV; i++) push(VEC[i][96:65]);
    wait_done("R11 stream end");
    chk(got_n == exp_n, "R10 write count", 32'(got_n), 32'(exp_n));
    stall_en = 1'b0;

    // R11 zero-length stream
    exp_n = 0; got_n = 0;
    go(0);
    wait_done("R11 zero length");

    // R2 without a base selected: base 0
    exp_addr[0] = 32'h00000010; exp_data[0] = 32'h77; exp_tag[0] = "R2"; exp_n = 1; got_n = 0;
    go(3);
    push(32'h03000001); push(32'h00000010); push(32'h00000077);
    wait_done("R2 no base");
    chk(got_n == 1, "R2 no base count", 32'(got_n), 32'h1);

    exp_n = 0; got_n = 0;
    // R7 zero count
    go(2); push(32'h03000000); expect_err(3'd1, "R7 zero count");
    // R7 contiguous overrun: needs 4, 3 remain
    go(3); push(32'h03000002); expect_err(3'd1, "R7 cont overrun");
    // R7 random overrun: needs 5, 4 remain
    go(4); push(32'h04000002); expect_err(3'd1, "R7 rand overrun");
    // R7 table overrun: 64 data words, 3 remain
    go(5); push(32'h08000123); push(32'h0A0000FF); expect_err(3'd1, "R7 table overrun");
    // R8 and R12: start deselects base; no-base beats length check
    go(1); push(32'h0A0000FF); expect_err(3'd2, "R8 R12 no base");
    // R6 miss on invalid entry
    go(1); push(32'h08000789); expect_err(3'd3, "R6 miss");
    // R9 unknown opcode, then held with words offered
    go(2); push(32'h05000000); expect_err(3'd4, "R9 opcode");
    @(negedge clk); cmd_valid = 1'b1; cmd_word = 32'h03000001;
    repeat (4) @(negedge clk);
    chk(err && err_code == 3'd4 && !cmd_ready, "R9 held", {29'b0, err_code}, 32'h4);
    cmd_valid = 1'b0;
    // R12 start clears error
    go(0);
    @(negedge clk);
    chk(!err && err_code == 3'd0, "R12 clear", {29'b0, err_code}, 32'h0);
    chk(got_n == 0, "R9 no writes after errors", 32'(got_n), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule